// File: doc/BRIEF.md
# Next Instruction Address Unit

This block holds the fetch address of a small 32-bit processor and works out where the next instruction fetch goes. Each instruction occupies four consecutive byte locations. In sequential flow the address therefore moves forward by four. When a branch is taken, or on an unconditional jump, the address moves to the current address plus a signed relative offset.

The block does not make the branch decision itself. The arithmetic unit evaluates the branch condition and returns a full-width word of 1 or 0. For the unconditional jump it always returns 1. A small decoder marks which opcodes are control-flow opcodes and whether that result word is exactly one. Two cascaded selects then pick between the sequential address and the relative target.

A registered program counter stores the fetch address. It has a synchronous reset and advances only while the enable input is high. The computed next address is also available combinationally, so the instruction memory can start on it early.

Top module: `nia_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pc_o` is 0 after that edge, whatever `en` is.
- R2: For any opcode that is not a control-flow opcode, `next_pc_o` equals `pc_o + 4` modulo 2^16, whatever `alu_res_i` and `offset_i` are. This includes the unused code 5'b10010 and 5'b11011.
- R3: For the conditional branch opcodes 5'b10011, 5'b10100, 5'b10101, 5'b10110 and 5'b10111, with `alu_res_i` equal to 32'h0000_0001, `next_pc_o` equals `pc_o + offset_i` modulo 2^16.
- R4: For any control-flow opcode, if `alu_res_i` is any value other than exactly 1 (for example 0, 2 or all ones), `next_pc_o` equals `pc_o + 4` modulo 2^16.
- R5: For the jump opcode 5'b11010, with `alu_res_i` equal to 1, `next_pc_o` equals `pc_o + offset_i` modulo 2^16.
- R6: Addresses are 16 bits wide. Bits 31..16 of every 32-bit sum are dropped, so a negative offset moves backward and a sum past 16'hFFFF wraps around.
- R7: While `en` is low and `rst` is low, `pc_o` keeps its value across clock edges.
- R8: While `en` is high and `rst` is low, `pc_o` after a rising edge equals the `next_pc_o` value that was present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Lets the program counter advance |
| opcode_i | input | 5 | Opcode of the instruction at `pc_o` |
| offset_i | input | 32 | Sign-extended relative offset from the instruction |
| alu_res_i | input | 32 | Condition result from the arithmetic unit |
| pc_o | output | 16 | Current fetch address (registered) |
| next_pc_o | output | 16 | Next fetch address (combinational) |

## Verification
`next_pc_o` depends combinationally on `pc_o` and on the three instruction inputs. The bench therefore checks it in the same cycle that the inputs are driven, a short settle time after driving them on the falling edge. `pc_o` is registered, so it changes exactly one rising edge after an enabled or reset cycle. The bench checks it on the next falling edge against a behavioural model that it updates at that edge. Directed cycles cover each branch opcode, the jump, non-exact results, wrap-around and negative offsets, hold and mid-run reset. A long pseudo-random run then compares both outputs on every cycle.

// File: rtl/nia_pkg.sv
package nia_pkg;

    typedef enum logic [4:0] {
        OP_BR_EQ  = 5'b10011,
        OP_BR_NE  = 5'b10100,
        OP_BR_LT  = 5'b10101,
        OP_BR_LTI = 5'b10110,
        OP_BR_GE  = 5'b10111,
        OP_JUMP   = 5'b11010
    } nia_ctrl_op_e;

    localparam int unsigned NIA_OP_W   = 5;
    localparam int unsigned NIA_DATA_W = 32;
    localparam int unsigned NIA_ADDR_W = 16;
    localparam int unsigned NIA_STEP   = 4;

endpackage

// File: rtl/nia_ctrl_decode.sv
module nia_ctrl_decode #(
    parameter int unsigned OP_W   = nia_pkg::NIA_OP_W,
    parameter int unsigned DATA_W = nia_pkg::NIA_DATA_W
) (
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] alu_res,
    output logic              is_jump,
    output logic              cond_met
);
    import nia_pkg::*;

    localparam logic [DATA_W-1:0] ONE_WORD = DATA_W'(1);

    always_comb begin
        case (opcode)
            OP_BR_EQ,
            OP_BR_NE,
            OP_BR_LT,
            OP_BR_LTI,
            OP_BR_GE,
            OP_JUMP:  is_jump = 1'b1;
            default:  is_jump = 1'b0;
        endcase
    end

    // Only an exact one counts as taken; any other word is not-taken.
    always_comb begin
        cond_met = (alu_res == ONE_WORD);
    end

endmodule

// File: rtl/nia_addr_gen.sv
module nia_addr_gen #(
    parameter int unsigned ADDR_W = nia_pkg::NIA_ADDR_W,
    parameter int unsigned DATA_W = nia_pkg::NIA_DATA_W,
    parameter int unsigned STEP   = nia_pkg::NIA_STEP
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] offset,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] tgt_addr
);
    localparam int unsigned HI_W = DATA_W - ADDR_W;

    logic [DATA_W-1:0] full_sum;
    logic              sum_unused_hi;

    always_comb begin
        seq_addr = pc + ADDR_W'(STEP);
        full_sum = {{HI_W{1'b0}}, pc} + offset;
        tgt_addr = full_sum[ADDR_W-1:0];
    end

    // Upper bits of the full-width sum are deliberately dropped.
    assign sum_unused_hi = ^full_sum[DATA_W-1:ADDR_W];

endmodule

// File: rtl/nia_addr_select.sv
module nia_addr_select #(
    parameter int unsigned ADDR_W = nia_pkg::NIA_ADDR_W
) (
    input  logic              is_jump,
    input  logic              cond_met,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [ADDR_W-1:0] tgt_addr,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] first_sel;

    always_comb begin
        first_sel = cond_met ? tgt_addr : seq_addr;
        next_addr = is_jump ? first_sel : seq_addr;
    end

endmodule

// File: rtl/nia_unit.sv
module nia_unit #(
    parameter int unsigned OP_W   = nia_pkg::NIA_OP_W,
    parameter int unsigned DATA_W = nia_pkg::NIA_DATA_W,
    parameter int unsigned ADDR_W = nia_pkg::NIA_ADDR_W,
    parameter int unsigned STEP   = nia_pkg::NIA_STEP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [OP_W-1:0]   opcode_i,
    input  logic [DATA_W-1:0] offset_i,
    input  logic [DATA_W-1:0] alu_res_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] next_pc_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } nia_state_t;

    nia_state_t        state_d;
    nia_state_t        state_q;
    logic              is_jump;
    logic              cond_met;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] tgt_addr;
    logic [ADDR_W-1:0] next_addr;

    nia_ctrl_decode #(
        .OP_W   (OP_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .opcode   (opcode_i),
        .alu_res  (alu_res_i),
        .is_jump  (is_jump),
        .cond_met (cond_met)
    );

    nia_addr_gen #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STEP   (STEP)
    ) u_gen (
        .pc       (state_q.pc),
        .offset   (offset_i),
        .seq_addr (seq_addr),
        .tgt_addr (tgt_addr)
    );

    nia_addr_select #(
        .ADDR_W (ADDR_W)
    ) u_select (
        .is_jump   (is_jump),
        .cond_met  (cond_met),
        .seq_addr  (seq_addr),
        .tgt_addr  (tgt_addr),
        .next_addr (next_addr)
    );

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.pc = '0;
        end else if (en) begin
            state_d.pc = next_addr;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign pc_o      = state_q.pc;
    assign next_pc_o = next_addr;

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (pc_o == '0)); // R1

    AST_SEQ_WHEN_PLAIN: assert property (@(posedge clk) disable iff (rst)
        !is_jump |-> (next_pc_o == ADDR_W'(pc_o + ADDR_W'(STEP)))); // R2

    AST_SEQ_WHEN_NOT_ONE: assert property (@(posedge clk) disable iff (rst)
        (alu_res_i != DATA_W'(1)) |-> (next_pc_o == ADDR_W'(pc_o + ADDR_W'(STEP)))); // R4

    AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
        (is_jump && cond_met) |-> (next_pc_o == ADDR_W'(pc_o + offset_i[ADDR_W-1:0]))); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(pc_o)); // R7

    AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        en |=> (pc_o == $past(next_pc_o))); // R8

endmodule

// File: tb/nia_unit_test.sv
module nia_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [4:0]  opcode_i = 5'd0;
    logic [31:0] offset_i = 32'd0;
    logic [31:0] alu_res_i = 32'd0;
    logic [15:0] pc_o;
    logic [15:0] next_pc_o;

    int total = 0;
    int bad = 0;
    logic [15:0] model_pc = 16'd0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #5 clk = ~clk;

    nia_unit uut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .opcode_i  (opcode_i),
        .offset_i  (offset_i),
        .alu_res_i (alu_res_i),
        .pc_o      (pc_o),
        .next_pc_o (next_pc_o)
    );

    function automatic bit is_ctrl(input logic [4:0] op);
        return op inside {5'b10011, 5'b10100, 5'b10101, 5'b10110, 5'b10111, 5'b11010};
    endfunction

    function automatic string req_of(input logic [4:0] op, input logic [31:0] alu);
        if (!is_ctrl(op)) return "R2";
        if (alu != 32'd1) return "R4";
        if (op == 5'b11010) return "R5";
        return "R3";
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    // One cycle: check pc, drive, check next, clock, update model.
    task automatic step(input logic r, input logic e, input logic [4:0] op,
                        input logic [31:0] off, input logic [31:0] alu, input string pc_req);
        logic [15:0] exp_next;
        logic [31:0] sum;
        @(negedge clk);
        check(pc_req, pc_o, model_pc);
        rst = r; en = e; opcode_i = op; offset_i = off; alu_res_i = alu;
        #1;
        sum = {16'd0, model_pc} + off;
        if (is_ctrl(op) && alu == 32'd1) exp_next = sum[15:0];
        else exp_next = model_pc + 16'd4;
        if (!r) check(req_of(op, alu), next_pc_o, exp_next);
        @(posedge clk);
        #1;
        if (r) model_pc = 16'd0;
        else if (e) model_pc = exp_next;
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        step(1, 0, 5'b00000, 32'd0, 32'd0, "R1");
        step(1, 1, 5'b11010, 32'd40, 32'd1, "R1");
        step(0, 1, 5'b00000, 32'd0, 32'd0, "R1");
        // R2: plain opcodes, result ignored
        step(0, 1, 5'b01000, 32'd100, 32'd1, "R8");
        step(0, 1, 5'b10010, 32'd100, 32'd1, "R8");
        step(0, 1, 5'b11011, 32'd100, 32'd1, "R8");
        step(0, 1, 5'b10001, 32'd100, 32'd1, "R8");
        // R3: each conditional branch taken
        step(0, 1, 5'b10011, 32'd16, 32'd1, "R8");
        step(0, 1, 5'b10100, 32'd32, 32'd1, "R8");
        step(0, 1, 5'b10101, 32'd8, 32'd1, "R8");
        step(0, 1, 5'b10110, 32'd12, 32'd1, "R8");
        step(0, 1, 5'b10111, 32'd20, 32'd1, "R8");
        // R4: not exactly one
        step(0, 1, 5'b10011, 32'd64, 32'd0, "R8");
        step(0, 1, 5'b10111, 32'd64, 32'd2, "R8");
        step(0, 1, 5'b11010, 32'd64, 32'hFFFF_FFFF, "R8");
        step(0, 1, 5'b10100, 32'd64, 32'h8000_0001, "R8");
        // R5: jump
        step(0, 1, 5'b11010, 32'd200, 32'd1, "R8");
        // R6: negative offset and wrap-around
        step(0, 1, 5'b11010, 32'hFFFF_FFF0, 32'd1, "R8");
        step(0, 1, 5'b10011, 32'h0001_FF00, 32'd1, "R6");
        step(0, 1, 5'b11010, 32'h0000_FFFC, 32'd1, "R6");
        step(0, 1, 5'b01000, 32'd0, 32'd0, "R6");
        // R7: hold with enable low
        step(0, 0, 5'b11010, 32'd300, 32'd1, "R7");
        step(0, 0, 5'b00000, 32'd0, 32'd0, "R7");
        step(0, 1, 5'b00000, 32'd0, 32'd0, "R7");
        // R1: reset mid-run
        step(1, 1, 5'b11010, 32'd300, 32'd1, "R8");
        step(0, 1, 5'b00000, 32'd0, 32'd0, "R1");
        // Random mix, compared every cycle
        for (int i = 0; i < 400; i++) begin
            logic [4:0]  op;
            logic [31:0] off;
            logic [31:0] alu;
            logic        e;
            next_rand();
            op = lfsr[4:0];
            if (lfsr[7:5] < 3'd4) op = 5'b10011 + 5'(lfsr[10:8] % 5);
            if (lfsr[12:11] == 2'b00) op = 5'b11010;
            next_rand();
            off = {{16{lfsr[15]}}, lfsr[15:2], 2'b00};
            next_rand();
            alu = (lfsr[2:0] < 3'd5) ? 32'd1 : ((lfsr[2:0] == 3'd5) ? 32'd0 : lfsr);
            e = (lfsr[9:8] != 2'b00);
            step((i % 97) == 96, e, op, off, alu, e ? "R8" : "R7");
        end
        @(negedge clk);
        check("R8", pc_o, model_pc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule